// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which DMA channel is served next when several channels ask for service in the same cycle. Each channel has a request bit and a 2-bit priority level set by software. The arbiter first finds the highest level among the channels that are requesting. It then breaks any tie in favour of the lowest channel index. The channels of two controllers share one index space. The first controller's channels take the low indices, so on a full tie they rank above the second controller's channels.

A grant is registered and one-hot. It stays on the chosen channel until that channel reports the end of its current item. The grant then drops at that edge, and arbitration runs again on the following edge. The transfer datapath, and the choice among several sources that feed one channel, lie outside this block. Each channel presents at most one active request bit.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant` is all zeros and `grantValid` is low.
- R2: When no channel requests and no grant is held, `grant` stays all zeros and `grantValid` stays low.
- R3: The priority of channel i sits in `prioVec[2i+1:2i]`. The encoding is 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. The arbiter grants a channel whose level is the highest among the requesters.
- R4: Among requesters that share the highest level present, the one with the lowest index is granted.
- R5: Channels 0 to NUM_A-1 belong to the first controller and channels NUM_A to NUM_A+NUM_B-1 (7 to 11 by default) belong to the second. On equal level, a first-controller channel wins over a second-controller channel. A second-controller channel still wins when its level is higher.
- R6: When no grant is held and at least one channel requests on a clock edge, `grant` becomes one-hot on that request's winner and `grantValid` goes high after that edge.
- R7: While a grant is held and `itemDone` is low, `grant` does not change. This holds even when requests are withdrawn, new requests arrive, or the priority fields change, including the granted channel's own field.
- R8: When `itemDone` is high on an edge while a grant is held, `grant` clears to zero at that edge. The next edge re-arbitrates among the requests present then.
- R9: `itemDone` asserted while no grant is held has no effect. A request on the same edge is still granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | NUM_A+NUM_B | Request bit per channel, first controller in the low bits |
| prioVec | input | 2*(NUM_A+NUM_B) | 2-bit priority level per channel |
| itemDone | input | 1 | Granted channel has finished its current item |
| grant | output | NUM_A+NUM_B | One-hot grant, zero when idle |
| grantValid | output | 1 | High while a grant is held |

## Verification
A wrong winner shows on `grant` one edge after the request is seen from idle, so each stimulus vector checks the grant on the first sample after that edge. A control state that has lost step with the grant register shows as `grantValid` out of agreement with `grant`. A grant that stays up after `itemDone` is also caught on the following sample. A hold that leaks is exposed by changing requests and levels under a live grant and sampling on every cycle. A skipped re-arbitration is exposed by checking the new winner exactly one edge after the release.

// File: rtl/dma_prio_arb_pkg.sv
package dma_prio_arb_pkg;

  localparam int LEVEL_W = 2;

  typedef enum logic [LEVEL_W-1:0] {
    LVL_LOW  = 2'b00,
    LVL_MED  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_TOP  = 2'b11
  } levelT;

  typedef struct packed {
    logic loadGrant;
    logic dropGrant;
  } arbStrobeT;

endpackage

// File: rtl/dma_arb_select.sv
module dma_arb_select
  import dma_prio_arb_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  arbStrobeT                 strobe,
  input  logic [NUM_CH-1:0]         reqVec,
  input  logic [LEVEL_W*NUM_CH-1:0] prioVec,
  output logic [NUM_CH-1:0]         grantQ
);

  levelT             levelArr [NUM_CH];
  levelT             topLevel;
  logic [NUM_CH-1:0] pick;
  logic              found;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_slice
      assign levelArr[g] = levelT'(prioVec[LEVEL_W*g +: LEVEL_W]);
    end
  endgenerate

  // Stage one: highest level among the active requesters.
  always_comb begin
    topLevel = LVL_LOW;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reqVec[i] && (levelArr[i] > topLevel)) topLevel = levelArr[i];
    end
  end

  // Stage two: lowest index at that level. The first group fills the low indices.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && reqVec[i] && (levelArr[i] == topLevel)) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= '0;
    end else if (strobe.dropGrant) begin
      grantQ <= '0;
    end else if (strobe.loadGrant) begin
      grantQ <= pick;
    end
  end

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_prio_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyReq,
  input  logic      itemDone,
  output arbStrobeT strobe,
  output logic      busy
);

  logic busyQ;

  always_comb begin
    strobe.loadGrant = !busyQ && anyReq;
    strobe.dropGrant = busyQ && itemDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.dropGrant) begin
      busyQ <= 1'b0;
    end else if (strobe.loadGrant) begin
      busyQ <= 1'b1;
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_prio_arb_pkg::*;
#(
  parameter int NUM_A = 7,
  parameter int NUM_B = 5,
  localparam int NUM_CH = NUM_A + NUM_B
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         reqVec,
  input  logic [LEVEL_W*NUM_CH-1:0] prioVec,
  input  logic                      itemDone,
  output logic [NUM_CH-1:0]         grant,
  output logic                      grantValid
);

  arbStrobeT strobe;

  dma_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (|reqVec),
    .itemDone (itemDone),
    .strobe   (strobe),
    .busy     (grantValid)
  );

  dma_arb_select #(.NUM_CH(NUM_CH)) u_sel (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqVec  (reqVec),
    .prioVec (prioVec),
    .grantQ  (grant)
  );

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] reqVec,
  input logic              itemDone,
  input logic [NUM_CH-1:0] grant,
  input logic              grantValid
);

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_valid_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grant != '0));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && reqVec == '0) |=> !grantValid);

  p_grant_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && reqVec != '0) |=> grantValid);

  p_grant_on_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> ((grant & $past(reqVec)) != '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !itemDone) |=> $stable(grant));

  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && itemDone) |=> !grantValid);

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqVec     (reqVec),
  .itemDone   (itemDone),
  .grant      (grant),
  .grantValid (grantValid)
);

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  reqVec = '0;
  logic [2*N-1:0] prioVec = '0;
  logic          itemDone = 1'b0;
  logic [N-1:0]  grant;
  logic          grantValid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arb u_dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .itemDone(itemDone), .grant(grant), .grantValid(grantValid)
  );

  // {request, priority field, expected one-hot grant}
  localparam logic [47:0] VECS [8] = '{
    {12'h001, 24'h000000, 12'h001},  // R3 single requester
    {12'h028, 24'h000C40, 12'h020},  // R3 ch5 very high beats ch3 medium
    {12'h214, 24'h080220, 12'h004},  // R4 three at high, lowest index
    {12'h801, 24'h400000, 12'h800},  // R5 second group wins on level
    {12'h120, 24'h010400, 12'h020},  // R5 tie across groups, first group
    {12'hFFF, 24'h000000, 12'h001},  // R4 all low
    {12'hFFF, 24'h300000, 12'h400},  // R3 one very high among all
    {12'h880, 24'h808000, 12'h080}   // R4 tie inside second group
  };

  task automatic check(input logic [N-1:0] expG, input logic expV, input string tag);
    checks++;
    if (grant !== expG || grantValid !== expV) begin
      errors++;
      $display("FAIL %s grant=%h valid=%b expected grant=%h valid=%b",
               tag, grant, grantValid, expG, expV);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check('0, 1'b0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check('0, 1'b0, "R1 after reset");

    repeat (3) @(negedge clk);
    check('0, 1'b0, "R2 idle no request");

    for (int v = 0; v < 8; v++) begin
      reqVec  = VECS[v][47:36];
      prioVec = VECS[v][35:12];
      @(negedge clk);
      check(VECS[v][11:0], 1'b1, $sformatf("R6 vector %0d winner", v));
      itemDone = 1'b1;
      reqVec   = '0;
      @(negedge clk);
      itemDone = 1'b0;
      check('0, 1'b0, $sformatf("R8 vector %0d release", v));
      @(negedge clk);
    end

    // R7: hold under changing requests and levels
    reqVec  = 12'h008;
    prioVec = 24'h000040;
    @(negedge clk);
    check(12'h008, 1'b1, "R7 initial grant ch3");
    reqVec  = 12'h001;
    prioVec = 24'h000003;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(12'h008, 1'b1, "R7 grant held");
    end
    itemDone = 1'b1;
    @(negedge clk);
    itemDone = 1'b0;
    check('0, 1'b0, "R8 release after hold");
    @(negedge clk);
    check(12'h001, 1'b1, "R8 re-arbitration next edge");
    itemDone = 1'b1;
    reqVec   = '0;
    @(negedge clk);
    check('0, 1'b0, "R8 second release");

    // R9: done while idle has no effect
    @(negedge clk);
    check('0, 1'b0, "R9 done while idle, no request");
    reqVec  = 12'h100;
    prioVec = 24'h000000;
    @(negedge clk);
    itemDone = 1'b0;
    check(12'h100, 1'b1, "R9 request granted despite done while idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired grant=%h expected completion", grant);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule